// File: doc/BRIEF.md
# Video Blanking Window Ramp Controller

This block opens and closes the active-video window of a raster line with a soft ramp instead of a hard switch. Its internal window flag goes high when the horizontal pixel counter reaches a programmable start count and low when it reaches a horizontal end count. A small level counter follows the window one step per enabled pixel. Each level maps to a gain that scales the three pixel components (luma and two colour-difference channels) on their way to the output, so an edge of the window becomes a short fade in or fade out.

A direction-select input decides how the external window pin is used. With the select low, the block drives its internal window out on the pin. With the select high, the pin is an input that can only hold the picture blanked: a high level leaves the internal window in charge, and a low level closes the window. Edges caused by the pin fade with the same steps as internal edges.

Top module: `vwr_win_ramp`

## Requirements
- R1: A synchronous reset clears the internal window and the ramp level. From the cycle after reset, `win_int` is 0, `y_out` is 0 and both colour-difference outputs are mid-scale (512 for 10-bit data).
- R2: On a cycle with `pix_en` high, `hcount == start_cnt` sets `win_int` from the next cycle on. `hcount == end_cnt` clears it, unless the start count matches in the same cycle, in which case the start wins.
- R3: The ramp has six levels with gains 0, 1/8, 3/8, 5/8, 7/8 and 1 (0, 32, 96, 160, 224 and 256 in units of 1/256). On each enabled pixel the level moves one step toward full while the effective window is high, and one step toward zero while it is low. A ramp that is cut short reverses from the level it has reached.
- R4: Outputs are registered. The pixel sampled on an enabled edge leaves with the gain of the level reached on that same edge. The pixel that matches the start count is still blanked, and the pixel after it is the first to carry 1/8.
- R5: The luma output is (Y*G + 128) >> 8, where G is the gain in units of 1/256. Zero gain gives 0, and full gain passes Y unchanged.
- R6: Each colour-difference output is 512 + floor(((C - 512)*G + 128) / 256). Zero gain gives 512, and full gain passes C unchanged.
- R7: With `dir_sel` high, the effective window is `win_int` AND `win_pin_in`. A low pin level closes the window at the same one-step-per-pixel rate. When the pin returns high, the window reopens the same way if `win_int` is high.
- R8: With `dir_sel` low, `win_pin_oe` is 1, `win_pin_out` equals `win_int`, and `win_pin_in` has no effect on the outputs. With `dir_sel` high, `win_pin_oe` is 0.
- R9: A cycle with `pix_en` low changes neither the window, the ramp level nor any pixel output.
- R10: When the window closes from full gain, the pixel that matches the end count is the last one at full gain. The next four enabled pixels carry 7/8, 5/8, 3/8 and 1/8, and the pixel after those is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel enable; one enabled cycle per pixel |
| hcount | input | HW (12) | Horizontal pixel counter |
| start_cnt | input | HW (12) | Window opening count (control register) |
| end_cnt | input | HW (12) | Window closing count from horizontal timing |
| dir_sel | input | 1 | 0: drive window onto pin, 1: pin is a blanking override input |
| win_pin_in | input | 1 | External window pin level, used when dir_sel is 1 |
| win_pin_out | output | 1 | Internal window driven toward the pin |
| win_pin_oe | output | 1 | Output enable for the window pin |
| y_in | input | DW (10) | Luma input |
| cb_in | input | DW (10) | First colour-difference input |
| cr_in | input | DW (10) | Second colour-difference input |
| y_out | output | DW (10) | Shaped luma |
| cb_out | output | DW (10) | Shaped first colour-difference |
| cr_out | output | DW (10) | Shaped second colour-difference |
| win_int | output | 1 | Internal window flag |

## Verification
The assertions run on every cycle. They check that the ramp level never jumps by more than one step, that idle cycles change nothing, that a start match opens the window, that a low override pin walks the level down, and that a zero level always shows as blanking levels on all three outputs. The exact gain at each pixel can only be shown by the bench's scenarios, which run a behavioural reference alongside the block. The same holds for the rounding of the luma and colour-difference products, the one-pixel offset of the opening and closing ramps, the reversal of a ramp cut short, the start-over-end priority and the pin being ignored while it is driven.

// File: rtl/vwr_pkg.sv
package vwr_pkg;

    // Number of fractional bits used by the per-pixel gain.
    localparam int VWR_GAIN_FRAC_DEF = 8;

    // Selects the blanking level and the arithmetic of a component lane.
    typedef enum logic {
        CH_LUMA   = 1'b0,
        CH_CHROMA = 1'b1
    } ch_kind_e;

    // Counter comparison results that steer the window flag.
    typedef struct packed {
        logic set_hit;
        logic clr_hit;
    } win_hits_t;

    // Gain of a ramp level, in units of 2**-frac.
    // Level 0 is blank, levels 1..len are odd eighths (for len = 4), above len is full.
    function automatic int ramp_gain(input int lvl, input int len, input int frac);
        if (lvl <= 0) begin
            return 0;
        end
        if (lvl > len) begin
            return 1 << frac;
        end
        return ((2 * lvl - 1) << frac) / (2 * len);
    endfunction

endpackage

// File: rtl/vwr_window.sv
module vwr_window
    import vwr_pkg::*;
#(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic [HW-1:0] hcount,
    input  logic [HW-1:0] start_cnt,
    input  logic [HW-1:0] end_cnt,
    output logic          win_q
);

    win_hits_t hits;

    always_comb begin
        hits.set_hit = (hcount == start_cnt);
        hits.clr_hit = (hcount == end_cnt);
    end

    // Opening match has priority over closing match.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
        end else if (pix_en) begin
            if (hits.set_hit) begin
                win_q <= 1'b1;
            end else if (hits.clr_hit) begin
                win_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vwr_ramp.sv
module vwr_ramp
    import vwr_pkg::*;
#(
    parameter  int RAMP_LEN  = 4,
    parameter  int GAIN_FRAC = VWR_GAIN_FRAC_DEF,
    localparam int LVL_MAX   = RAMP_LEN + 1,
    localparam int LVL_W     = $clog2(LVL_MAX + 1),
    localparam int GW        = GAIN_FRAC + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             target,
    output logic [LVL_W-1:0] level_q,
    output logic [GW-1:0]    gain_nxt
);

    logic [LVL_W-1:0] level_nxt;

    always_comb begin
        level_nxt = level_q;
        if (target && (level_q != LVL_W'(LVL_MAX))) begin
            level_nxt = level_q + 1'b1;
        end else if (!target && (level_q != '0)) begin
            level_nxt = level_q - 1'b1;
        end
        gain_nxt = GW'(ramp_gain(int'(level_nxt), RAMP_LEN, GAIN_FRAC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (pix_en) begin
            level_q <= level_nxt;
        end
    end

endmodule

// File: rtl/vwr_scale.sv
module vwr_scale
    import vwr_pkg::*;
#(
    parameter  int       DW        = 10,
    parameter  int       GAIN_FRAC = VWR_GAIN_FRAC_DEF,
    parameter  ch_kind_e KIND      = CH_LUMA,
    localparam int       GW        = GAIN_FRAC + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic [DW-1:0] din,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] dout
);

    localparam int PW = DW + GW + 2;
    localparam logic signed [PW-1:0] MID_S  = PW'(2 ** (DW - 1));
    localparam logic signed [PW-1:0] HALF_S = PW'(2 ** (GAIN_FRAC - 1));
    localparam logic [DW-1:0] RST_VAL = (KIND == CH_CHROMA) ? DW'(2 ** (DW - 1)) : '0;

    logic signed [PW-1:0] s_in;
    logic signed [PW-1:0] s_gain;
    logic signed [PW-1:0] s_prod;
    logic signed [PW-1:0] s_rnd;
    logic signed [PW-1:0] s_res;
    logic        [DW-1:0] d_nxt;

    // Chroma is scaled about mid-scale, luma about zero; both round half up.
    always_comb begin
        s_in = $signed({{(PW - DW){1'b0}}, din});
        if (KIND == CH_CHROMA) begin
            s_in = s_in - MID_S;
        end
        s_gain = $signed({{(PW - GW){1'b0}}, gain});
        s_prod = s_in * s_gain;
        s_rnd  = (s_prod + HALF_S) >>> GAIN_FRAC;
        s_res  = (KIND == CH_CHROMA) ? (s_rnd + MID_S) : s_rnd;
        d_nxt  = DW'(s_res);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= RST_VAL;
        end else if (pix_en) begin
            dout <= d_nxt;
        end
    end

endmodule

// File: rtl/vwr_win_ramp.sv
module vwr_win_ramp
    import vwr_pkg::*;
#(
    parameter int HW        = 12,
    parameter int DW        = 10,
    parameter int RAMP_LEN  = 4,
    parameter int GAIN_FRAC = VWR_GAIN_FRAC_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic [HW-1:0] hcount,
    input  logic [HW-1:0] start_cnt,
    input  logic [HW-1:0] end_cnt,
    input  logic          dir_sel,
    input  logic          win_pin_in,
    output logic          win_pin_out,
    output logic          win_pin_oe,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out,
    output logic          win_int
);

    localparam int LVL_MAX = RAMP_LEN + 1;
    localparam int LVL_W   = $clog2(LVL_MAX + 1);
    localparam int GW      = GAIN_FRAC + 1;
    localparam int NCH     = 3;

    logic             win_q;
    logic             target;
    logic [LVL_W-1:0] level_q;
    logic [GW-1:0]    gain_nxt;
    logic [DW-1:0]    lane_in  [NCH];
    logic [DW-1:0]    lane_out [NCH];

    vwr_window #(.HW(HW)) u_window (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .hcount    (hcount),
        .start_cnt (start_cnt),
        .end_cnt   (end_cnt),
        .win_q     (win_q)
    );

    // The pin can only keep the picture blanked; it never opens the window.
    assign target = win_q & (~dir_sel | win_pin_in);

    vwr_ramp #(.RAMP_LEN(RAMP_LEN), .GAIN_FRAC(GAIN_FRAC)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .target   (target),
        .level_q  (level_q),
        .gain_nxt (gain_nxt)
    );

    assign lane_in[0] = y_in;
    assign lane_in[1] = cb_in;
    assign lane_in[2] = cr_in;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        vwr_scale #(
            .DW        (DW),
            .GAIN_FRAC (GAIN_FRAC),
            .KIND      ((i == 0) ? CH_LUMA : CH_CHROMA)
        ) u_scale (
            .clk    (clk),
            .rst    (rst),
            .pix_en (pix_en),
            .din    (lane_in[i]),
            .gain   (gain_nxt),
            .dout   (lane_out[i])
        );
    end

    assign y_out       = lane_out[0];
    assign cb_out      = lane_out[1];
    assign cr_out      = lane_out[2];
    assign win_int     = win_q;
    assign win_pin_out = win_q;
    assign win_pin_oe  = ~dir_sel;

endmodule

// File: rtl/vwr_chk.sv
module vwr_chk #(
    parameter int HW      = 12,
    parameter int DW      = 10,
    parameter int LVL_W   = 3,
    parameter int LVL_MAX = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic [HW-1:0]    hcount,
    input logic [HW-1:0]    start_cnt,
    input logic             dir_sel,
    input logic             win_pin_in,
    input logic             win_int,
    input logic [LVL_W-1:0] level,
    input logic [DW-1:0]    y_out,
    input logic [DW-1:0]    cb_out,
    input logic [DW-1:0]    cr_out
);

    localparam logic [DW-1:0] MID = DW'(2 ** (DW - 1));

    AST_RESET_CLOSED: assert property (@(posedge clk)
        rst |=> (!win_int && level == '0 && y_out == '0 && cb_out == MID)); // R1

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hcount == start_cnt) |=> win_int); // R2

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> (level == $past(level) || level == $past(level) + 1'b1
                    || level + 1'b1 == $past(level))); // R3

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= LVL_MAX); // R3

    AST_OVERRIDE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (pix_en && dir_sel && !win_pin_in && level != '0)
        |=> (level + 1'b1 == $past(level))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(level) && $stable(win_int) && $stable(y_out)
                     && $stable(cb_out) && $stable(cr_out))); // R9

    AST_ZERO_BLANK: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> (y_out == '0 && cb_out == MID && cr_out == MID)); // R5 R6

endmodule

bind vwr_win_ramp vwr_chk #(
    .HW      (HW),
    .DW      (DW),
    .LVL_W   (LVL_W),
    .LVL_MAX (LVL_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .hcount     (hcount),
    .start_cnt  (start_cnt),
    .dir_sel    (dir_sel),
    .win_pin_in (win_pin_in),
    .win_int    (win_int),
    .level      (level_q),
    .y_out      (y_out),
    .cb_out     (cb_out),
    .cr_out     (cr_out)
);

// File: tb/vwr_win_ramp_tb.sv
module vwr_win_ramp_tb;

    localparam int CLK_P = 10;
    localparam int HW    = 12;
    localparam int DW    = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          pix_en;
    logic [HW-1:0] hcount, start_cnt, end_cnt;
    logic          dir_sel, win_pin_in, win_pin_out, win_pin_oe;
    logic [DW-1:0] y_in, cb_in, cr_in, y_out, cb_out, cr_out;
    logic          win_int;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";

    // Reference state
    int m_win, m_lvl, m_y, m_cb, m_cr;

    always #(CLK_P / 2) clk = ~clk;

    vwr_win_ramp u_dut (
        .clk (clk), .rst (rst), .pix_en (pix_en), .hcount (hcount),
        .start_cnt (start_cnt), .end_cnt (end_cnt), .dir_sel (dir_sel),
        .win_pin_in (win_pin_in), .win_pin_out (win_pin_out), .win_pin_oe (win_pin_oe),
        .y_in (y_in), .cb_in (cb_in), .cr_in (cr_in),
        .y_out (y_out), .cb_out (cb_out), .cr_out (cr_out), .win_int (win_int)
    );

    function automatic int gain_of(int lvl);
        case (lvl)
            0: return 0;
            1: return 32;
            2: return 96;
            3: return 160;
            4: return 224;
            default: return 256;
        endcase
    endfunction

    function automatic int chroma_ref(int c, int g);
        int d;
        d = c - 512;
        return 512 + ((d * g + 128) >>> 8);
    endfunction

    always @(posedge clk) begin : model
        int tgt;
        int g;
        if (rst) begin
            m_win = 0; m_lvl = 0; m_y = 0; m_cb = 512; m_cr = 512;
        end else if (pix_en) begin
            tgt = (m_win == 1 && (dir_sel == 1'b0 || win_pin_in == 1'b1)) ? 1 : 0;
            if (int'(hcount) == int'(start_cnt)) m_win = 1;
            else if (int'(hcount) == int'(end_cnt)) m_win = 0;
            if (tgt == 1 && m_lvl < 5) m_lvl = m_lvl + 1;
            else if (tgt == 0 && m_lvl > 0) m_lvl = m_lvl - 1;
            g    = gain_of(m_lvl);
            m_y  = (int'(y_in) * g + 128) >>> 8;
            m_cb = chroma_ref(int'(cb_in), g);
            m_cr = chroma_ref(int'(cr_in), g);
        end
    end

    task automatic chk(string sig, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, sig, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_P / 4);
        chk("win_int", int'(win_int), m_win);
        chk("y_out", int'(y_out), m_y);
        chk("cb_out", int'(cb_out), m_cb);
        chk("cr_out", int'(cr_out), m_cr);
        chk("win_pin_oe", int'(win_pin_oe), dir_sel ? 0 : 1);
        chk("win_pin_out", int'(win_pin_out), m_win);
    endtask

    task automatic set_data(int mode);
        case (mode)
            1: begin y_in = 10'd1023; cb_in = 10'd0;    cr_in = 10'd1023; end
            2: begin y_in = 10'd1;    cb_in = 10'd1023; cr_in = 10'd513;  end
            default: begin
                y_in  = DW'($urandom_range(0, 1023));
                cb_in = DW'($urandom_range(0, 1023));
                cr_in = DW'($urandom_range(0, 1023));
            end
        endcase
    endtask

    // One line of npix pixels; pin is low for lo_a <= hcount < lo_b.
    task automatic run_line(int npix, bit gaps, int lo_a, int lo_b, int mode);
        for (int hc = 0; hc < npix; hc++) begin
            if (gaps) begin
                pix_en = 1'b0;
                hcount = HW'(hc);
                win_pin_in = 1'b0;
                set_data(0);
                tick();
            end
            pix_en = 1'b1;
            hcount = HW'(hc);
            win_pin_in = (hc >= lo_a && hc < lo_b) ? 1'b0 : 1'b1;
            set_data(mode);
            tick();
        end
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; pix_en = 1'b0; hcount = '0; start_cnt = 12'd10; end_cnt = 12'd40;
        dir_sel = 1'b0; win_pin_in = 1'b1; y_in = '0; cb_in = '0; cr_in = '0;
        cur_req = "R1 reset";
        repeat (3) tick();
        chk("R1 y_out reset", int'(y_out), 0);
        chk("R1 cb_out reset", int'(cb_out), 512);
        chk("R1 win reset", int'(win_int), 0);
        rst = 1'b0;

        cur_req = "R2 R4 R5 R6 R10 basic line";
        run_line(60, 1'b0, 0, 0, 0);
        run_line(60, 1'b0, 0, 0, 0);

        cur_req = "R8 pin ignored while driven";
        run_line(60, 1'b0, 15, 50, 0);

        cur_req = "R9 idle cycles";
        run_line(60, 1'b1, 0, 0, 0);

        cur_req = "R7 override mid-window";
        dir_sel = 1'b1;
        run_line(60, 1'b0, 20, 30, 0);
        cur_req = "R7 override across opening";
        run_line(60, 1'b0, 0, 13, 0);
        cur_req = "R7 override short pulse";
        run_line(60, 1'b0, 25, 27, 0);

        cur_req = "R3 ramp reversal";
        dir_sel = 1'b0; start_cnt = 12'd20; end_cnt = 12'd22;
        run_line(40, 1'b0, 0, 0, 0);
        cur_req = "R3 wrapping window";
        start_cnt = 12'd30; end_cnt = 12'd10;
        run_line(40, 1'b0, 0, 0, 0);
        run_line(40, 1'b0, 0, 0, 0);

        cur_req = "R5 R6 extremes";
        start_cnt = 12'd5; end_cnt = 12'd30;
        run_line(40, 1'b0, 0, 0, 1);
        run_line(40, 1'b0, 0, 0, 2);

        cur_req = "R2 start beats end";
        start_cnt = 12'd15; end_cnt = 12'd15;
        run_line(30, 1'b0, 0, 0, 0);
        run_line(30, 1'b0, 0, 0, 0);

        cur_req = "R1 reset mid-line";
        rst = 1'b1; pix_en = 1'b1;
        tick();
        chk("R1 y_out after reset", int'(y_out), 0);
        chk("R1 cr_out after reset", int'(cr_out), 512);
        chk("R1 win after reset", int'(win_int), 0);
        rst = 1'b0;
        run_line(20, 1'b0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule